// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Controller

This block arbitrates interrupts among several internal sources of one peripheral that shares an enable-in/enable-out priority chain with other devices. Each source raises a pending level and supplies an 8-bit vector. The block keeps one in-service bit per source. It drives the active-low interrupt line and gates the chain output so that lower devices stay quiet while this device is pending or busy. It answers the acknowledge cycle with the vector of its winning source.

In-service bits are not cleared by a register write. The block watches instruction fetches on the processor bus. When a fetch of byte ED is followed directly by a fetch of byte 4D, the block treats the pair as a return from interrupt. A one-byte command register sets which source heads the internal priority ring. A source's own request logic lies outside the block; it clears its pending level when it sees its acknowledge strobe.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset no source is in service, the command register holds 0, `int_no` is high and `data_oe_o` is low. With `iei_i` high and nothing pending, `ieo_o` is high.
- R2: `ieo_o` is low whenever `iei_i` is low.
- R3: Outside the window that follows an ED fetch, any pending source holds `ieo_o` low. Any in-service source always holds `ieo_o` low.
- R4: `int_no` is low exactly when some source is pending, is not in service, sees `iei_i` high, and has no source of higher internal priority in service. An in-service source blocks sources of equal and lower priority but not higher ones.
- R5: At the first clock edge with `m1_ni` low, the block captures the highest-priority pending, not-in-service source that sees the full chain enable. That enable includes `iei_i` as it stands at that edge. While `m1_ni` and `iorq_ni` are both low, `data_o` carries that source's vector (source s occupies bits `vec_i[8s+7:8s]`), `data_oe_o` is high and `ack_o` is one-hot on it. With no captured source, `data_oe_o` stays low.
- R6: The acknowledge sets the in-service bit of the captured source.
- R7: A fetch (`m1_ni` and `rd_ni` low, `iorq_ni` high) of 0xED, followed directly by a fetch of 0x4D, clears one in-service bit. That bit belongs to the highest-priority in-service source, and it is cleared only if `iei_i` is high. Each fetch is evaluated at the first edge after it ends.
- R8: After an ED fetch and up to the next fetch, pending sources no longer hold `ieo_o` low; only in-service sources do.
- R9: A 0x4D fetch that does not directly follow an ED fetch clears nothing.
- R10: A write takes effect on an edge where `cs_ni` and `iorq_ni` are low, `rd_ni` and `m1_ni` are high, and `addr_i` is 4'b1110. Its value v in `data_i[1:0]` (for 3 sources) makes source v the highest priority. The order then runs v, v+1, … modulo the source count. A value at or above the source count is ignored.
- R11: A command write with `m1_ni` low has no effect.
- R12: A return sequence seen while `iei_i` is low leaves all in-service bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m1_ni | input | 1 | First-machine-cycle strobe, active low |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Processor data bus, as seen by the block |
| data_o | output | 8 | Vector driven during acknowledge |
| data_oe_o | output | 1 | Enable for data_o onto the bus |
| iei_i | input | 1 | Chain enable from higher devices |
| ieo_o | output | 1 | Chain enable to lower devices |
| int_no | output | 1 | Interrupt request, active low |
| req_i | input | N_SRC | Pending level per source |
| vec_i | input | 8*N_SRC | Vector per source |
| ack_o | output | N_SRC | One-hot acknowledge strobe to the winning source |

## Verification
The bench nests interrupts. A low-priority source is served, then a higher one interrupts it, then a middle one is blocked until the return sequence. A design that cleared the wrong in-service bit, or let an in-service source block higher ones, would present the wrong vector or drive `int_no` at the wrong time. Broken sequences (ED, other byte, 4D) and returns with `iei_i` low are counted through the chain output. A design that cleared eagerly would release `ieo_o` one return too early. Command writes are checked through the acknowledge vector, including writes with out-of-range values and writes during an M1 cycle. An acknowledge with `iei_i` low at M1 fall must put nothing on the bus.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam logic [7:0] RET_PREFIX = 8'hED;
  localparam logic [7:0] RET_OPCODE = 8'h4D;
  localparam logic [3:0] CMD_ADDR   = 4'b1110;
endpackage

// File: rtl/irq_prio_net.sv
module irq_prio_net #(
  parameter int N_SRC = 3,
  parameter int IW    = 2
) (
  input  logic [IW-1:0]    head_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] ius_i,
  input  logic             ed_seen_i,
  input  logic             iei_i,
  output logic             ieo_o,
  output logic [N_SRC-1:0] can_int_o,
  output logic             win_vld_o,
  output logic [IW-1:0]    win_idx_o,
  output logic             rel_vld_o,
  output logic [IW-1:0]    rel_idx_o
);
  always_comb begin
    logic en_full;
    logic en_svc;
    int   s;
    en_full   = iei_i;
    en_svc    = iei_i;
    can_int_o = '0;
    win_vld_o = 1'b0;
    win_idx_o = '0;
    rel_vld_o = 1'b0;
    rel_idx_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      s = int'(head_i) + k;
      if (s >= N_SRC) s = s - N_SRC;
      can_int_o[s] = req_i[s] & ~ius_i[s] & en_svc;
      if (!win_vld_o && en_full && req_i[s] && !ius_i[s]) begin
        win_vld_o = 1'b1;
        win_idx_o = IW'(s);
      end
      if (!rel_vld_o && en_svc && ius_i[s]) begin
        rel_vld_o = 1'b1;
        rel_idx_o = IW'(s);
      end
      // pending stops blocking once the return prefix was fetched
      en_full = en_full & ~ius_i[s] & ~(req_i[s] & ~ed_seen_i);
      en_svc  = en_svc & ~ius_i[s];
    end
    ieo_o = en_full;
  end
endmodule

// File: rtl/irq_reti_snoop.sv
module irq_reti_snoop
  import irq_chain_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       m1_ni,
  input  logic       rd_ni,
  input  logic       iorq_ni,
  input  logic [7:0] data_i,
  output logic       ed_seen_o,
  output logic       reti_o
);
  logic       fetch, fetch_q, fetch_end;
  logic [7:0] byte_q;

  assign fetch     = ~m1_ni & ~rd_ni & iorq_ni;
  assign fetch_end = fetch_q & ~fetch;
  assign reti_o    = fetch_end & ed_seen_o & (byte_q == RET_OPCODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q   <= 1'b0;
      byte_q    <= '0;
      ed_seen_o <= 1'b0;
    end else begin
      fetch_q <= fetch;
      if (fetch) byte_q <= data_i;
      if (fetch_end) ed_seen_o <= ~reti_o & (byte_q == RET_PREFIX);
    end
  end
endmodule

// File: rtl/irq_svc_state.sv
module irq_svc_state #(
  parameter int N_SRC = 3,
  parameter int IW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             m1_ni,
  input  logic             iorq_ni,
  input  logic             win_vld_i,
  input  logic [IW-1:0]    win_idx_i,
  input  logic             rel_i,
  input  logic [IW-1:0]    rel_idx_i,
  output logic [N_SRC-1:0] ius_o,
  output logic             acking_o,
  output logic [IW-1:0]    ack_idx_o
);
  logic m1_q, ack_vld_q;

  assign acking_o = ack_vld_q & ~m1_ni & ~iorq_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1_q      <= 1'b1;
      ack_vld_q <= 1'b0;
      ack_idx_o <= '0;
      ius_o     <= '0;
    end else begin
      m1_q <= m1_ni;
      if (m1_ni) begin
        ack_vld_q <= 1'b0;
      end else if (m1_q) begin
        // chain frozen at start of M1
        ack_vld_q <= win_vld_i;
        ack_idx_o <= win_idx_i;
      end
      if (acking_o) ius_o[ack_idx_o] <= 1'b1;
      if (rel_i) ius_o[rel_idx_i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               m1_ni,
  input  logic               iorq_ni,
  input  logic               rd_ni,
  input  logic               cs_ni,
  input  logic [3:0]         addr_i,
  input  logic [7:0]         data_i,
  output logic [7:0]         data_o,
  output logic               data_oe_o,
  input  logic               iei_i,
  output logic               ieo_o,
  output logic               int_no,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [8*N_SRC-1:0] vec_i,
  output logic [N_SRC-1:0]   ack_o
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IW-1:0]    head_q;
  logic [N_SRC-1:0] ius_q, can_int;
  logic             ed_seen, reti, win_vld, rel_vld, acking;
  logic [IW-1:0]    win_idx, rel_idx, ack_idx;
  logic             cmd_wr;

  assign cmd_wr = ~cs_ni & ~iorq_ni & rd_ni & m1_ni & (addr_i == CMD_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_q <= '0;
    else if (cmd_wr && (int'(data_i[IW-1:0]) < N_SRC)) head_q <= data_i[IW-1:0];
  end

  irq_prio_net #(.N_SRC(N_SRC), .IW(IW)) u_net (
    .head_i(head_q), .req_i(req_i), .ius_i(ius_q), .ed_seen_i(ed_seen),
    .iei_i(iei_i), .ieo_o(ieo_o), .can_int_o(can_int),
    .win_vld_o(win_vld), .win_idx_o(win_idx),
    .rel_vld_o(rel_vld), .rel_idx_o(rel_idx)
  );

  irq_reti_snoop u_snoop (
    .clk_i(clk_i), .rst_ni(rst_ni), .m1_ni(m1_ni), .rd_ni(rd_ni),
    .iorq_ni(iorq_ni), .data_i(data_i), .ed_seen_o(ed_seen), .reti_o(reti)
  );

  irq_svc_state #(.N_SRC(N_SRC), .IW(IW)) u_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .m1_ni(m1_ni), .iorq_ni(iorq_ni),
    .win_vld_i(win_vld), .win_idx_i(win_idx),
    .rel_i(reti & rel_vld), .rel_idx_i(rel_idx),
    .ius_o(ius_q), .acking_o(acking), .ack_idx_o(ack_idx)
  );

  assign int_no    = ~|can_int;
  assign data_oe_o = acking;
  assign data_o    = acking ? vec_i[8*int'(ack_idx) +: 8] : 8'h00;

  always_comb begin
    ack_o = '0;
    if (acking) ack_o[ack_idx] = 1'b1;
  end
endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk #(
  parameter int N_SRC = 3,
  parameter int IW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             m1_ni,
  input logic             iorq_ni,
  input logic             iei_i,
  input logic             ieo_o,
  input logic             int_no,
  input logic             data_oe_o,
  input logic [N_SRC-1:0] ack_o,
  input logic [N_SRC-1:0] ius_q,
  input logic [IW-1:0]    head_q
);
  // R2
  ieo_follows_iei_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iei_i |-> !ieo_o);
  // R3
  ieo_blocked_by_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ieo_o |-> (ius_q == '0));
  // R4
  int_needs_iei_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no |-> iei_i);
  // R5
  vec_only_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!m1_ni && !iorq_ni));
  // R5
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o) && ((ack_o != '0) == data_oe_o));
  // R6
  svc_set_by_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ius_q & ~$past(ius_q)) != '0) |-> $past(data_oe_o));
  // R11
  no_cmd_in_m1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m1_ni |=> (head_q == $past(head_q)));
endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.N_SRC(N_SRC), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m1_ni(m1_ni), .iorq_ni(iorq_ni),
  .iei_i(iei_i), .ieo_o(ieo_o), .int_no(int_no), .data_oe_o(data_oe_o),
  .ack_o(ack_o), .ius_q(ius_q), .head_q(head_q)
);

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;
  localparam int N = 3;

  logic         clk_i = 0, rst_ni = 0;
  logic         m1_ni = 1, iorq_ni = 1, rd_ni = 1, cs_ni = 1;
  logic [3:0]   addr_i = 0;
  logic [7:0]   data_i = 0;
  logic [7:0]   data_o;
  logic         data_oe_o, iei_i = 1, ieo_o, int_no;
  logic [N-1:0] req_i = 0, ack_o;
  logic [8*N-1:0] vec_i = {8'h30, 8'h20, 8'h10};

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_ius = 0;
  int           m_head = 0;
  bit           m_ed = 0;
  logic e_ieo, e_int, e_wv, e_rv;
  int   e_wi, e_ri;
  logic [7:0] last_vec;
  logic       last_oe;

  irq_chain_ctrl #(.N_SRC(N)) u_irq_chain_ctrl (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic void meval();
    bit ef, es;
    int s;
    ef = iei_i; es = iei_i;
    e_int = 1; e_wv = 0; e_rv = 0; e_wi = 0; e_ri = 0;
    for (int k = 0; k < N; k++) begin
      s = (m_head + k) % N;
      if (req_i[s] && !m_ius[s] && es) e_int = 0;
      if (!e_wv && ef && req_i[s] && !m_ius[s]) begin e_wv = 1; e_wi = s; end
      if (!e_rv && es && m_ius[s]) begin e_rv = 1; e_ri = s; end
      ef = ef & !m_ius[s] & !(req_i[s] & !m_ed);
      es = es & !m_ius[s];
    end
    e_ieo = ef;
  endfunction

  task automatic check_static(string r);
    #2;
    meval();
    chk({r, " ieo"}, ieo_o, e_ieo);
    chk({r, " int"}, int_no, e_int);
  endtask

  task automatic write_cmd(input logic [7:0] v, input logic m1v);
    @(negedge clk_i);
    cs_ni = 0; iorq_ni = 0; rd_ni = 1; m1_ni = m1v; addr_i = 4'b1110; data_i = v;
    @(negedge clk_i);
    cs_ni = 1; iorq_ni = 1; m1_ni = 1; addr_i = 0;
    if (m1v && int'(v[1:0]) < N) m_head = v[1:0];
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk_i);
    m1_ni = 0; rd_ni = 0; data_i = b;
    @(negedge clk_i);
    m1_ni = 1; rd_ni = 1;
    meval();
    @(negedge clk_i);
    if (m_ed && b == 8'h4D) begin
      if (e_rv) m_ius[e_ri] = 0;
      m_ed = 0;
    end else m_ed = (b == 8'hED);
  endtask

  task automatic reti();
    fetch(8'hED); fetch(8'h4D);
  endtask

  // R5 R6: acknowledge, compares against model, source drops request
  task automatic do_ack(string r);
    @(negedge clk_i);
    m1_ni = 0;
    meval();
    @(negedge clk_i);
    iorq_ni = 0;
    #2;
    last_vec = data_o; last_oe = data_oe_o;
    chk({r, " oe"}, data_oe_o, e_wv);
    if (e_wv) begin
      chk({r, " vec"}, data_o, 32'(vec_i[8*e_wi +: 8]));
      chk({r, " ack"}, ack_o, 32'(1 << e_wi));
    end
    @(negedge clk_i);
    m1_ni = 1; iorq_ni = 1;
    if (e_wv) begin m_ius[e_wi] = 1; req_i[e_wi] = 0; end
    @(negedge clk_i);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk("R1 ieo", ieo_o, 1); chk("R1 int", int_no, 1); chk("R1 oe", data_oe_o, 0);
    // R2
    iei_i = 0; #2 chk("R2 ieo low", ieo_o, 0);
    @(negedge clk_i); iei_i = 1; #2 chk("R2 ieo high", ieo_o, 1);
    // R3 R4
    req_i = 3'b100; check_static("R3/R4 pending");
    chk("R3 ieo pending", ieo_o, 0); chk("R4 int pending", int_no, 0);
    do_ack("R5 src2"); chk("R5 vec src2", last_vec, 8'h30);
    check_static("R6 svc2"); chk("R6 int off", int_no, 1);
    req_i = 3'b001; check_static("R4 higher interrupts");
    chk("R4 higher int", int_no, 0);
    do_ack("R5 src0"); chk("R5 vec src0", last_vec, 8'h10);
    req_i = 3'b010; check_static("R4 blocked"); chk("R4 blocked int", int_no, 1);
    fetch(8'hED); check_static("R8 ed svc");
    fetch(8'h4D); check_static("R7 release src0"); chk("R7 int src1", int_no, 0);
    do_ack("R7 src1"); chk("R7 vec src1", last_vec, 8'h20);
    // R9: broken sequence, then count returns
    fetch(8'hED); fetch(8'h00); fetch(8'h4D); check_static("R9 broken");
    reti(); check_static("R9 one reti"); chk("R9 ieo still low", ieo_o, 0);
    reti(); check_static("R7 second reti"); chk("R7 ieo free", ieo_o, 1);
    // R8
    req_i = 3'b100; check_static("R8 pend"); chk("R8 pend ieo", ieo_o, 0);
    fetch(8'hED); check_static("R8 after ed"); chk("R8 ieo up", ieo_o, 1);
    fetch(8'h00); check_static("R8 window end"); chk("R8 ieo down", ieo_o, 0);
    // R12
    do_ack("R12 setup");
    iei_i = 0; reti(); iei_i = 1; check_static("R12 no clear");
    chk("R12 ieo", ieo_o, 0);
    reti(); check_static("R12 later clear"); chk("R12 ieo up", ieo_o, 1);
    // R10
    write_cmd(8'h02, 1); req_i = 3'b101; do_ack("R10 head2");
    chk("R10 vec", last_vec, 8'h30); req_i = 0; reti();
    write_cmd(8'h03, 1); req_i = 3'b101; do_ack("R10 bad value");
    chk("R10 bad ignored", last_vec, 8'h30); req_i = 0; reti();
    // R11
    write_cmd(8'h00, 0); req_i = 3'b101; do_ack("R11 m1 write");
    chk("R11 ignored", last_vec, 8'h30); req_i = 0; reti();
    write_cmd(8'h01, 1); req_i = 3'b011; do_ack("R10 head1");
    chk("R10 vec head1", last_vec, 8'h20); req_i = 0; reti();
    write_cmd(8'h00, 1);
    // R5 iei sampled at M1 fall
    req_i = 3'b001; iei_i = 0; do_ack("R5 iei low");
    chk("R5 no vector", last_oe, 0); iei_i = 1; req_i = 0;
    check_static("R1 idle");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: req_i = N'($urandom());
        1: iei_i = ($urandom_range(0, 4) != 0);
        2: write_cmd(8'($urandom_range(0, 3)), 1);
        3, 4: do_ack("R5 random");
        5: reti();
        6: fetch(($urandom_range(0, 1) != 0) ? 8'hED : 8'h4D);
        default: fetch(8'($urandom()));
      endcase
      @(negedge clk_i);
      check_static("R4 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule